// File: doc/BRIEF.md
# Dark-Frame Fixed-Pattern Noise Canceller

This block removes per-pixel fixed-pattern noise from a raster pixel stream. A calibration pass is run while the lens is covered: the block sums a power-of-two number of consecutive dark frames pixel by pixel into an on-chip array. The array stands in for an external frame memory. When the pass ends, the block divides each sum by the frame count with a right shift, and the result is the black reference for that pixel. In normal operation, every incoming pixel has the reference value at its own raster position subtracted from it. A result below zero is clamped to zero.

Pixels enter and leave on valid/ready streams. An input beat is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat and its frame-start flag hold still, and no new input beat is taken. A sender may hold `in_valid` high for any length of time. The calibration command is a one-cycle pulse that carries the log2 of the frame count. `cal_done` is a level signal that reports a finished reference.

Before the first calibration completes, and during any calibration pass, pixels pass through unchanged.

Top module: `fpn_canceller`

## Requirements
- R1: After reset, `out_valid` is 0, `cal_done` is 0 and `in_ready` is 1.
- R2: Until a calibration has completed, and from the cycle after any `cal_start` until the next completion, each output pixel equals its input pixel.
- R3: Once a calibration has completed, each output pixel equals the input pixel minus the reference at its position. The reference is the sum of the dark pixels at that position, shifted right by `cal_log2`.
- R4: `cal_log2` values 0, 1, 2 and 3 select 1, 2, 4 and 8 dark frames. Eight frames of the value 1023 produce a reference of 1023 without overflow.
- R5: Accumulation starts at the first frame-start beat that is accepted in a cycle after the `cal_start` cycle. A frame-start beat accepted in the same cycle as `cal_start` does not begin the pass.
- R6: `cal_done` rises in the cycle after the accepting edge of the last pixel (position COLS*ROWS-1) of the last dark frame. That beat still passes through uncorrected. `cal_done` is 0 in the cycle after `cal_start`.
- R7: A beat with `in_sof` high is raster position 0. Each following accepted beat takes the next position, and the position wraps to 0 after COLS*ROWS-1.
- R8: Output appears one cycle after acceptance. While `out_valid` is 1 and `out_ready` is 0, the output stays stable and `in_ready` is 0.
- R9: When the reference exceeds the input pixel, the output is 0.
- R10: `out_sof` carries the `in_sof` value of the beat being output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | PIX_W | Input pixel |
| in_sof | input | 1 | Input beat is the first pixel of a frame |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | PIX_W | Corrected pixel |
| out_sof | output | 1 | Output beat is the first pixel of a frame |
| cal_start | input | 1 | One-cycle calibration command |
| cal_log2 | input | LW | log2 of the dark-frame count (0..MAX_LOG2) |
| cal_done | output | 1 | Reference captured and correction active |

## Verification
Two functions can fall in the same cycle: a calibration command and an accepted frame-start beat. The bench provokes this by raising `cal_start` on the same beat as `in_sof`, then sends a frame of bright pixels followed by a dark frame. It judges the result by the corrected output after the pass ends, which must reflect only the dark frame, and by `cal_done` staying low after the bright frame. A second overlap occurs when the last dark pixel completes calibration. That beat must leave uncorrected, and the very next beat must be corrected.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE  = 2'd0,
    CAL_ARMED = 2'd1,
    CAL_ACCUM = 2'd2
  } cal_state_t;

endpackage

// File: rtl/fpn_pos_counter.sv
// Raster position tracker: a frame-start beat is position 0.
module fpn_pos_counter #(
  parameter int NPIX = 512,
  localparam int AW = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          sof,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [AW-1:0] pos_q;

  assign addr = sof ? '0 : pos_q;
  assign last = (addr == AW'(NPIX - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (beat) begin
      pos_q <= last ? '0 : addr + AW'(1);
    end
  end
endmodule

// File: rtl/fpn_ref_mem.sv
// On-chip accumulator/reference array with combinational read.
module fpn_ref_mem #(
  parameter int DEPTH = 512,
  parameter int W     = 13,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/fpn_cal_ctrl.sv
// Calibration sequencer: arm, accumulate N frames, then enable correction.
module fpn_cal_ctrl
  import fpn_pkg::*;
#(
  parameter int MAX_LOG2 = 3,
  localparam int LW = $clog2(MAX_LOG2 + 1),
  localparam int FW = (MAX_LOG2 > 0) ? MAX_LOG2 : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cal_start,
  input  logic [LW-1:0] cal_log2,
  input  logic          beat,
  input  logic          sof,
  input  logic          last,
  output logic          accum_en,
  output logic          first_frame,
  output logic          done,
  output logic          ref_valid,
  output logic [LW-1:0] shift
);
  cal_state_t    state_q;
  logic [FW-1:0] fidx_q;
  logic [FW-1:0] fcur;
  logic [FW-1:0] flimit;

  assign accum_en    = (state_q == CAL_ACCUM) || ((state_q == CAL_ARMED) && sof);
  assign fcur        = (state_q == CAL_ACCUM) ? fidx_q : '0;
  assign first_frame = (fcur == '0);
  assign flimit      = FW'((32'd1 << shift) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= CAL_IDLE;
      fidx_q    <= '0;
      done      <= 1'b0;
      ref_valid <= 1'b0;
      shift     <= '0;
    end else if (cal_start) begin
      state_q   <= CAL_ARMED;
      fidx_q    <= '0;
      done      <= 1'b0;
      ref_valid <= 1'b0;
      shift     <= cal_log2;
    end else if (beat && accum_en) begin
      if (last) begin
        if (fcur == flimit) begin
          state_q   <= CAL_IDLE;
          done      <= 1'b1;
          ref_valid <= 1'b1;
        end else begin
          state_q <= CAL_ACCUM;
          fidx_q  <= fcur + FW'(1);
        end
      end else begin
        state_q <= CAL_ACCUM;
        fidx_q  <= fcur;
      end
    end
  end
endmodule

// File: rtl/fpn_canceller.sv
module fpn_canceller
  import fpn_pkg::*;
#(
  parameter int PIX_W    = 10,
  parameter int COLS     = 32,
  parameter int ROWS     = 16,
  parameter int MAX_LOG2 = 3,
  localparam int NPIX  = COLS * ROWS,
  localparam int AW    = (NPIX > 1) ? $clog2(NPIX) : 1,
  localparam int ACC_W = PIX_W + MAX_LOG2,
  localparam int LW    = $clog2(MAX_LOG2 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sof,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sof,
  input  logic             cal_start,
  input  logic [LW-1:0]    cal_log2,
  output logic             cal_done
);
  logic             beat;
  logic [AW-1:0]    addr;
  logic             last;
  logic             accum_en;
  logic             first_frame;
  logic             ref_valid;
  logic [LW-1:0]    shift;
  logic [ACC_W-1:0] rdata;
  logic [ACC_W-1:0] wdata;
  logic [ACC_W-1:0] pix_ext;
  logic [ACC_W-1:0] ref_val;
  logic [PIX_W-1:0] corrected;

  assign in_ready = !out_valid || out_ready;
  assign beat     = in_valid && in_ready;
  assign pix_ext  = ACC_W'(in_data);

  fpn_pos_counter #(.NPIX(NPIX)) pos_i (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof),
    .addr(addr), .last(last)
  );

  fpn_cal_ctrl #(.MAX_LOG2(MAX_LOG2)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_log2(cal_log2),
    .beat(beat), .sof(in_sof), .last(last),
    .accum_en(accum_en), .first_frame(first_frame),
    .done(cal_done), .ref_valid(ref_valid), .shift(shift)
  );

  // Sums are written in place: first frame overwrites, later frames add.
  assign wdata = first_frame ? pix_ext : (rdata + pix_ext);

  fpn_ref_mem #(.DEPTH(NPIX), .W(ACC_W)) mem_i (
    .clk(clk), .we(beat && accum_en), .addr(addr),
    .wdata(wdata), .rdata(rdata)
  );

  assign ref_val = rdata >> shift;

  always_comb begin
    if (!ref_valid)               corrected = in_data;
    else if (ref_val > pix_ext)   corrected = '0;
    else                          corrected = PIX_W'(pix_ext - ref_val);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= corrected;
        out_sof  <= in_sof;
      end
    end
  end
endmodule

// File: rtl/fpn_canceller_chk.sv
module fpn_canceller_chk #(
  parameter int PIX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PIX_W-1:0] in_data,
  input logic             in_sof,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_data,
  input logic             out_sof,
  input logic             cal_start,
  input logic             cal_done,
  input logic             ref_valid
);
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof)));

  p_stall_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !ref_valid) |=> (out_valid && out_data == $past(in_data)));

  p_no_increase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_data <= $past(in_data)));

  p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> (!cal_done && !ref_valid));

  p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done) |-> $past(in_valid && in_ready));

  p_sof_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_sof == $past(in_sof)));
endmodule

bind fpn_canceller fpn_canceller_chk #(.PIX_W(PIX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_sof(in_sof), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
  .cal_start(cal_start), .cal_done(cal_done), .ref_valid(ref_valid)
);

// File: tb/fpn_canceller_tb_top.sv
module fpn_canceller_tb_top;
  localparam int COLS = 4;
  localparam int ROWS = 2;
  localparam int NPIX = COLS * ROWS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_data = '0;
  logic       in_sof = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [9:0] out_data;
  logic       out_sof;
  logic       cal_start = 1'b0;
  logic [1:0] cal_log2 = '0;
  logic       cal_done;

  int n_checks = 0;
  int n_fail   = 0;
  int refm [NPIX];
  bit ref_on = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fpn_canceller #(.COLS(COLS), .ROWS(ROWS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .cal_start(cal_start), .cal_log2(cal_log2), .cal_done(cal_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_pix(input int v, input int p);
    int r;
    if (!ref_on) return v;
    r = v - refm[p];
    return (r < 0) ? 0 : r;
  endfunction

  // One beat, accepted at the next edge, output checked at the following negedge.
  task automatic push(input int d, input bit s, input int exp, input string req, input bit cal = 0);
    @(negedge clk);
    in_valid = 1'b1; in_data = 10'(d); in_sof = s; cal_start = cal;
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; cal_start = 1'b0;
    @(negedge clk);
    chk(out_valid && out_data == 10'(exp), req, int'(out_data), exp);
    chk(out_sof == s, "R10 out_sof", int'(out_sof), int'(s));
  endtask

  function automatic int dark(input int f, input int p);
    return (p * 53 + f * 29 + 7) % 200 + 20;
  endfunction

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(cal_done == 1'b0, "R1 cal_done", int'(cal_done), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_passthru;
    for (int p = 0; p < NPIX; p++) push(p * 131 % 1024, p == 0, p * 131 % 1024, "R2 passthru");
  endtask

  task automatic pulse_cal(input int lg);
    @(negedge clk);
    cal_start = 1'b1; cal_log2 = 2'(lg);
    @(negedge clk);
    cal_start = 1'b0;
    chk(cal_done == 1'b0, "R6 done cleared", int'(cal_done), 0);
    ref_on = 0;
  endtask

  // Dark frames from the calibration pulse onward; output passes raw (R2).
  task automatic t_calib(input int lg, input bit all_max);
    int sums [NPIX];
    int n;
    n = 1 << lg;
    pulse_cal(lg);
    for (int p = 0; p < NPIX; p++) sums[p] = 0;
    for (int f = 0; f < n; f++) begin
      for (int p = 0; p < NPIX; p++) begin
        int v;
        v = all_max ? 1023 : dark(f, p);
        sums[p] += v;
        push(v, p == 0, v, "R2 raw during calib R4");
        if (!(f == n - 1 && p == NPIX - 1))
          chk(cal_done == 1'b0, "R6 done early", int'(cal_done), 0);
      end
    end
    chk(cal_done == 1'b1, "R6 done after last", int'(cal_done), 1);
    for (int p = 0; p < NPIX; p++) refm[p] = sums[p] >> lg;
    ref_on = 1;
  endtask

  task automatic t_run(input int seed);
    for (int p = 0; p < NPIX; p++) begin
      int v;
      v = (p * 97 + seed) % 1024;
      if (p == 1) v = 0;
      push(v, p == 0, expect_pix(v, p), (p == 1) ? "R9 clamp" : "R3 subtract");
    end
  endtask

  task automatic t_restart_sof;
    for (int p = 0; p < 3; p++) push(500 + p, p == 0, expect_pix(500 + p, p), "R7 partial");
    for (int p = 0; p < NPIX + 2; p++)
      push(600 + p, p == 0, expect_pix(600 + p, p % NPIX), "R7 restart and wrap");
  endtask

  task automatic t_backpressure;
    int ea, eb;
    ea = expect_pix(700, 0);
    eb = expect_pix(800, 1);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 10'd700; in_sof = 1'b1;
    @(posedge clk); #1;
    in_data = 10'd800; in_sof = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R8 ready low on stall", int'(in_ready), 0);
    chk(out_data == 10'(ea), "R8 first beat", int'(out_data), ea);
    repeat (2) @(negedge clk);
    chk(out_valid && out_data == 10'(ea), "R8 held", int'(out_data), ea);
    out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid && out_data == 10'(eb), "R8 second beat", int'(out_data), eb);
  endtask

  // cal_start with a frame-start beat in the same cycle: that frame is not dark data.
  task automatic t_coincident;
    cal_log2 = 2'd0;
    for (int p = 0; p < NPIX; p++) push(1000, p == 0, (p == 0) ? expect_pix(1000, 0) : 1000, "R5 same-cycle frame", p == 0);
    ref_on = 0;
    chk(cal_done == 1'b0, "R5 not started", int'(cal_done), 0);
    for (int p = 0; p < NPIX; p++) push(dark(5, p), p == 0, dark(5, p), "R5 dark frame raw");
    chk(cal_done == 1'b1, "R5 done after one frame", int'(cal_done), 1);
    for (int p = 0; p < NPIX; p++) refm[p] = dark(5, p);
    ref_on = 1;
    t_run(41);
  endtask

  task automatic t_overflow;
    t_calib(3, 1);
    push(1023, 1'b1, 0, "R4 ref 1023");
    push(0, 1'b0, 0, "R4 ref 1023 clamp");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_passthru();
    t_calib(2, 0);
    t_run(300);
    t_restart_sof();
    t_backpressure();
    t_coincident();
    t_calib(1, 0);
    t_run(77);
    t_overflow();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule